// File: doc/BRIEF.md
# I2C Master Start Generator with Collision Detection

This block produces the Start condition for one I2C master and watches both bus lines while it does so. A single-cycle request strobe begins the sequence. The block checks that the bus is free and waits one baud interval with both lines released. It then pulls SDA low, waits a second baud interval, and pulls SCL low. The two intervals come from a 7-bit reload value. The outputs are drive-low enables for open-drain pads. Both line inputs pass through a two-stage synchroniser inside the block before any decision uses them.

A clock held low by another device while SDA is still high counts as a bus collision. A request made on a bus that is already low also counts as a collision. In both cases the block sets a sticky collision flag, drops its busy status and releases both lines. If another master pulls SDA low during the first interval, the block joins that Start at once and restarts its second interval. This case is not a collision.

After a successful Start the block raises a one-cycle done pulse and sets a sticky done flag. It keeps both lines low until the next stage signals a hand-off. Software clears each sticky flag with its own clear strobe.

Top module: `i2c_start_gen`

## Requirements
- R1: The line inputs reach the decision logic through two register stages. A raw line change applied before clock edge k is acted on at edge k+2.
- R2: If a start request is sampled while idle with either synchronised line low, collFlag is set at that same edge. busy stays low and neither line is driven.
- R3: With L = reload value (or 1 if the reload value is 0), an accepted request at edge E0 makes busy high. sdaDriveLow rises after edge E0+L.
- R4: In the first interval, a synchronised SCL low while synchronised SDA is high sets collFlag, returns the block to idle (busy low), and leaves both lines released at that same edge.
- R5: In the first interval, a synchronised SDA low makes sdaDriveLow rise at that same edge and reloads the counter. No collision is flagged.
- R6: sclDriveLow rises L edges after sdaDriveLow rises. SCL sampled low during this second interval is not a collision.
- R7: When sclDriveLow rises, startDone is high for exactly one cycle and doneFlag is set. Both lines stay driven low and busy is low until handOff, which releases both lines.
- R8: doneFlag stays set until clrDone is pulsed, and collFlag stays set until clrColl is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R9: A start request while a sequence is running, or while the lines are held after completion, is ignored. The timing of the running sequence is unchanged and no collision is flagged.
- R10: A reload value of 0 gives first and second intervals of one cycle each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start request strobe |
| handOff | input | 1 | Next stage takes over the lines; return to idle |
| reloadVal | input | 7 | Baud interval reload value |
| sdaIn | input | 1 | Raw SDA line level |
| sclIn | input | 1 | Raw SCL line level |
| clrDone | input | 1 | Clear doneFlag |
| clrColl | input | 1 | Clear collFlag |
| sdaDriveLow | output | 1 | Pull SDA low when high |
| sclDriveLow | output | 1 | Pull SCL low when high |
| busy | output | 1 | Start sequence in progress |
| startDone | output | 1 | One-cycle pulse on Start completion |
| doneFlag | output | 1 | Sticky Start-completed flag |
| collFlag | output | 1 | Sticky bus collision flag |

## Verification
The checker tests every cycle for the rules that a single step can decide. These are the abort on a busy bus, the collision on a held clock in the first interval, the early SDA assertion, and the absence of collisions in the second interval. It also checks the one-cycle done pulse, the SDA-before-SCL order and the flag persistence. The exact interval lengths are only shown by the bench scenarios. So are the two-cycle synchroniser delay, the zero-reload case and the ignoring of repeated requests. The bench measures each of these in cycles from the request edge against values derived from the reload setting.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_HELD   = 2'd3
  } startState_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic setDone;
    logic setColl;
  } startStrobe_t;
endpackage

// File: rtl/i2c_start_dp.sv
module i2c_start_dp
  import i2c_start_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaIn,
  input  logic             sclIn,
  input  logic [CNT_W-1:0] reloadVal,
  input  startStrobe_t     strobe,
  input  logic             clrDone,
  input  logic             clrColl,
  output logic             sdaSync,
  output logic             sclSync,
  output logic             cntOne,
  output logic             doneFlag,
  output logic             collFlag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SYNC_STAGES-1:0] sdaPipe;
  logic [SYNC_STAGES-1:0] sclPipe;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       loadVal;

  // Line synchronisers, reset to the released (high) level
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sdaPipe[i] <= 1'b1;
          sclPipe[i] <= 1'b1;
        end else if (i == 0) begin
          sdaPipe[i] <= sdaIn;
          sclPipe[i] <= sclIn;
        end else begin
          sdaPipe[i] <= sdaPipe[(i == 0) ? 0 : i-1];
          sclPipe[i] <= sclPipe[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign sdaSync = sdaPipe[SYNC_STAGES-1];
  assign sclSync = sclPipe[SYNC_STAGES-1];

  // A zero reload counts as one cycle
  assign loadVal = (reloadVal == '0) ? ONE : reloadVal;
  assign cntOne  = (cnt <= ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.loadCnt) cnt <= loadVal;
    else if (strobe.decCnt)  cnt <= cnt - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      collFlag <= 1'b0;
    end else begin
      if (strobe.setDone)  doneFlag <= 1'b1;
      else if (clrDone)    doneFlag <= 1'b0;
      if (strobe.setColl)  collFlag <= 1'b1;
      else if (clrColl)    collFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
  import i2c_start_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         handOff,
  input  logic         sdaSync,
  input  logic         sclSync,
  input  logic         cntOne,
  output startStrobe_t strobe,
  output logic         sdaDriveLow,
  output logic         sclDriveLow,
  output logic         busy,
  output logic         startDone
);
  startState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (!sdaSync || !sclSync) begin
            strobe.setColl = 1'b1;            // bus already busy
          end else begin
            strobe.loadCnt = 1'b1;
            nextState      = ST_FIRST;
          end
        end
      end
      ST_FIRST: begin
        if (!sclSync && sdaSync) begin
          strobe.setColl = 1'b1;              // clock held by another device
          nextState      = ST_IDLE;
        end else if (!sdaSync || cntOne) begin
          strobe.loadCnt = 1'b1;              // early or regular SDA assertion
          nextState      = ST_SECOND;
        end else begin
          strobe.decCnt  = 1'b1;
        end
      end
      ST_SECOND: begin
        if (cntOne) begin
          strobe.setDone = 1'b1;
          nextState      = ST_HELD;
        end else begin
          strobe.decCnt  = 1'b1;
        end
      end
      ST_HELD: begin
        if (handOff) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startDone <= 1'b0;
    end else begin
      state     <= nextState;
      startDone <= strobe.setDone;
    end
  end

  assign sdaDriveLow = (state == ST_SECOND) || (state == ST_HELD);
  assign sclDriveLow = (state == ST_HELD);
  assign busy        = (state == ST_FIRST) || (state == ST_SECOND);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             handOff,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             sdaIn,
  input  logic             sclIn,
  input  logic             clrDone,
  input  logic             clrColl,
  output logic             sdaDriveLow,
  output logic             sclDriveLow,
  output logic             busy,
  output logic             startDone,
  output logic             doneFlag,
  output logic             collFlag
);
  startStrobe_t strobe;
  logic sdaSync, sclSync, cntOne;

  i2c_start_dp #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .sclIn(sclIn),
    .reloadVal(reloadVal), .strobe(strobe),
    .clrDone(clrDone), .clrColl(clrColl),
    .sdaSync(sdaSync), .sclSync(sclSync), .cntOne(cntOne),
    .doneFlag(doneFlag), .collFlag(collFlag)
  );

  i2c_start_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .handOff(handOff),
    .sdaSync(sdaSync), .sclSync(sclSync), .cntOne(cntOne),
    .strobe(strobe), .sdaDriveLow(sdaDriveLow), .sclDriveLow(sclDriveLow),
    .busy(busy), .startDone(startDone)
  );
endmodule

// File: rtl/i2c_start_chk.sv
module i2c_start_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic clrDone,
  input logic clrColl,
  input logic sdaSync,
  input logic sclSync,
  input logic sdaDriveLow,
  input logic sclDriveLow,
  input logic busy,
  input logic startDone,
  input logic doneFlag,
  input logic collFlag
);
  // idle = released, not busy
  logic idle;
  assign idle = !busy && !sdaDriveLow && !sclDriveLow;

  a_r2_busy_bus_abort: assert property (@(posedge clk) disable iff (!rstN)
    (idle && startReq && (!sdaSync || !sclSync)) |=> (collFlag && !busy && !sdaDriveLow));

  a_r4_held_clock_coll: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sdaDriveLow && sdaSync && !sclSync) |=> (collFlag && !busy && !sdaDriveLow && !sclDriveLow));

  a_r5_early_sda: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sdaDriveLow && !sdaSync) |=> (sdaDriveLow && busy));

  a_r6_no_coll_second: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sdaDriveLow && !collFlag) |=> !collFlag);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    startDone |=> !startDone);

  a_r7_done_state: assert property (@(posedge clk) disable iff (!rstN)
    startDone |-> (doneFlag && sclDriveLow && sdaDriveLow && !busy));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !clrDone) |=> doneFlag);

  a_r8_coll_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (collFlag && !clrColl) |=> collFlag);

  always_comb begin
    if (rstN) begin
      a_r7_order: assert (!sclDriveLow || sdaDriveLow);
    end
  end
endmodule

bind i2c_start_gen i2c_start_chk u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .clrDone(clrDone),
  .clrColl(clrColl), .sdaSync(sdaSync), .sclSync(sclSync),
  .sdaDriveLow(sdaDriveLow), .sclDriveLow(sclDriveLow), .busy(busy),
  .startDone(startDone), .doneFlag(doneFlag), .collFlag(collFlag)
);

// File: tb/i2c_start_gen_bench.sv
module i2c_start_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, handOff = 1'b0, clrDone = 1'b0, clrColl = 1'b0;
  logic [6:0] reloadVal = 7'd5;
  logic extSdaLow = 1'b0, extSclLow = 1'b0;
  logic sdaIn, sclIn;
  logic sdaDriveLow, sclDriveLow, busy, startDone, doneFlag, collFlag;

  int total = 0, bad = 0;
  int cyc = 0;
  int reqEdge = 0;
  int sdaSeen = -1;
  bit finished = 0;

  typedef struct {
    int    kind;   // 0 = done, 1 = collision
    int    sdaD;   // edges from request to SDA drive, -1 for never
    int    endD;   // edges from request to done or collision
    string tag;
  } exp_t;
  exp_t q[$];

  // wired-AND bus model
  assign sdaIn = !(sdaDriveLow || extSdaLow);
  assign sclIn = !(sclDriveLow || extSclLow);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_start_gen u_i2c_start_gen (
    .clk(clk), .rstN(rstN), .startReq(startReq), .handOff(handOff),
    .reloadVal(reloadVal), .sdaIn(sdaIn), .sclIn(sclIn),
    .clrDone(clrDone), .clrColl(clrColl),
    .sdaDriveLow(sdaDriveLow), .sclDriveLow(sclDriveLow), .busy(busy),
    .startDone(startDone), .doneFlag(doneFlag), .collFlag(collFlag)
  );

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pop expected items as results appear
  logic collPrev = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (sdaDriveLow && sdaSeen < 0) sdaSeen = cyc - reqEdge;
      if ((startDone || (collFlag && !collPrev)) && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " kind"}, startDone ? 0 : 1, e.kind);
        check({e.tag, " sda delay"}, sdaSeen, e.sdaD);
        check({e.tag, " end delay"}, cyc - reqEdge, e.endD);
      end
      collPrev = collFlag;
    end
  end

  // driver: pre = line held low before request (0 none, 1 sda, 2 scl)
  // ev = event at edge evAt after request (0 none, 1 sda low, 2 scl low, 3 extra request)
  task automatic runStart(input int n, input int pre, input int ev, input int evAt,
                          input int kind, input int sdaD, input int endD, input string tag);
    exp_t e;
    reloadVal = 7'(n);
    if (pre == 1) extSdaLow = 1'b1;
    if (pre == 2) extSclLow = 1'b1;
    repeat (4) @(negedge clk);
    e.kind = kind; e.sdaD = sdaD; e.endD = endD; e.tag = tag;
    q.push_back(e);
    sdaSeen  = -1;
    reqEdge  = cyc + 1;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int w = 0; w < 400 && q.size() > 0; w++) begin
      if (ev != 0 && cyc == reqEdge + evAt - 1) begin
        if (ev == 1) extSdaLow = 1'b1;
        if (ev == 2) extSclLow = 1'b1;
        if (ev == 3) startReq = 1'b1;
      end
      @(negedge clk);
      startReq = 1'b0;
    end
    if (q.size() > 0) begin
      total++; bad++;
      $display("FAIL %s no result actual=0 expected=1", tag);
      q.delete();
    end
  endtask

  task automatic finishRun;
    extSdaLow = 1'b0;
    extSclLow = 1'b0;
    handOff = 1'b1; clrDone = 1'b1; clrColl = 1'b1;
    @(negedge clk);
    handOff = 1'b0; clrDone = 1'b0; clrColl = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 reset sda release", int'(sdaDriveLow), 0);
    check("R7 reset scl release", int'(sclDriveLow), 0);
    check("R8 reset flags", int'(doneFlag | collFlag | busy | startDone), 0);

    // R3 R6 R7 normal start, L=5
    runStart(5, 0, 0, 0, 0, 5, 10, "R3 normal");
    check("R7 lines held after done", int'(sdaDriveLow && sclDriveLow && !busy), 1);
    repeat (3) @(negedge clk);
    check("R8 done flag sticky", int'(doneFlag), 1);
    // R9 request while held is ignored
    startReq = 1'b1; @(negedge clk); startReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 held ignores request", int'(sclDriveLow && !busy && !collFlag), 1);
    clrDone = 1'b1; @(negedge clk); clrDone = 1'b0;
    check("R8 done flag cleared", int'(doneFlag), 0);
    finishRun();
    check("R7 handoff releases", int'(sdaDriveLow | sclDriveLow), 0);

    // R10 zero reload
    runStart(0, 0, 0, 0, 0, 1, 2, "R10 zero reload");
    finishRun();

    // R2 busy bus
    runStart(5, 1, 0, 0, 1, -1, 0, "R2 sda low");
    check("R2 not busy after abort", int'(busy | sdaDriveLow), 0);
    repeat (3) @(negedge clk);
    check("R8 coll flag sticky", int'(collFlag), 1);
    finishRun();
    check("R8 coll flag cleared", int'(collFlag), 0);
    runStart(5, 2, 0, 0, 1, -1, 0, "R2 scl low");
    finishRun();

    // R4 R1 clock held low in first interval: raw at edge 3, acted on at edge 5
    runStart(10, 0, 2, 3, 1, -1, 5, "R4 R1 scl collision");
    check("R4 released after collision", int'(busy | sdaDriveLow | sclDriveLow), 0);
    finishRun();

    // R5 R1 early SDA: raw at edge 2, SDA driven at edge 4, SCL 10 later
    runStart(10, 0, 1, 2, 0, 4, 14, "R5 R1 early sda");
    check("R5 no collision", int'(collFlag), 0);
    finishRun();

    // R6 SCL low during second interval (edges 6..12)
    runStart(6, 0, 2, 8, 0, 6, 12, "R6 scl low second");
    check("R6 no collision", int'(collFlag), 0);
    finishRun();

    // R9 extra request during first interval
    runStart(8, 0, 3, 3, 0, 8, 16, "R9 extra request");
    check("R9 no collision", int'(collFlag), 0);
    finishRun();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule